// File: doc/BRIEF.md
# Translation-Triggered Prefetch Engine

This block sits in the request path of a DRAM memory controller, between a page-table walker and the DRAM command port. Every read from the walker takes a slot in a small transaction queue and is sent to DRAM. Some reads carry a marker saying they fetch the final page-table entry of a walk, together with the index of the wanted cache line inside the target page. For such a read the block reserves a second slot. That slot holds a dependent line read. The line read cannot start yet, because its address is not known.

When the entry's data comes back from DRAM, the block returns it to the walker like any other read. It then decodes the entry. If the entry is valid, the block combines the physical frame number with the line index to form the target line address, and it releases the reserved slot so that the line read can go to DRAM. When that read completes, the line goes out as a fill toward the last-level cache. By the time the walker replays its access, the line is already in that cache. If the entry is not valid, the reserved slot is freed and no fill is produced.

DRAM is modelled as a request port with a ready/valid handshake and a response port that returns data tagged with the slot number that issued the read.

Top module: `xlat_prefetch_engine`

## Requirements
- R1: A request with `req_leaf` low causes exactly one DRAM read at `req_addr`. No fill results from it. One cycle after its DRAM response, `rsp_valid` is high with the request's tag and the returned data.
- R2: The queue has `SLOTS` (8) entries. A request with `req_leaf` low is accepted only while at least one slot is free, and a request with `req_leaf` high only while at least two are free. Otherwise `req_ready` is low and the request waits.
- R3: A marked request produces a dependent line read. That read never reaches the DRAM port before the DRAM response of its page-table entry.
- R4: The dependent line read uses address `{pte[51:12], line_index[5:0], 6'b000000}`. One cycle after its DRAM response, `fill_valid` is high with that address in `fill_addr` and the returned data in `fill_data`.
- R5: If bit 0 (present) of the returned entry is 0, no line read is issued and no fill is produced. Both slots are free again one cycle after the response.
- R6: The data of a page-table-entry read is returned on the walker response port with its tag one cycle after its DRAM response, whatever its present bit.
- R7: Each DRAM response produces exactly one output in the next cycle: a walker response for plain and entry reads, or a fill for line reads. The two outputs are never high together.
- R8: After reset no output is valid, no DRAM read is pending, and a marked request would be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walker read request valid |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_leaf | input | 1 | Request fetches a last-level page-table entry |
| req_line | input | 6 | Cache-line index inside the target page (marked requests) |
| req_addr | input | 52 | Physical address of the read |
| req_tag | input | 4 | Walker tag echoed on the response |
| mem_valid | output | 1 | DRAM read request valid |
| mem_ready | input | 1 | DRAM accepts the read |
| mem_addr | output | 52 | DRAM read address |
| mem_id | output | 3 | Slot number of the read |
| memr_valid | input | 1 | DRAM read data valid |
| memr_id | input | 3 | Slot number of the returning read |
| memr_data | input | 64 | DRAM read data |
| rsp_valid | output | 1 | Walker response valid |
| rsp_tag | output | 4 | Tag of the answered request |
| rsp_data | output | 64 | Read data for the walker |
| fill_valid | output | 1 | Last-level cache fill valid |
| fill_addr | output | 52 | Line address of the fill |
| fill_data | output | 64 | Fetched line data |

## Verification
The hardest state to reach is a queue with exactly one free slot while a marked request waits at the head. Only then does the two-slot admission rule differ from the one-slot rule. The bench reaches it by holding the DRAM port not-ready while seven plain reads fill seven slots, and then presenting a marked request. It checks that the request is held off until DRAM drains. Bursts of mixed requests then use entry addresses whose present bit alternates and random DRAM back-pressure. Released line reads therefore compete with fresh requests for the port, and dropped prefetches free their slots while other reads are still in flight.

// File: rtl/xpf_pkg.sv
package xpf_pkg;
  // Slot life cycle: free, waiting to issue, in flight at DRAM, held until its entry returns
  typedef enum logic [1:0] {SL_FREE = 2'd0, SL_WAIT = 2'd1, SL_BUSY = 2'd2, SL_HOLD = 2'd3} slot_st_t;
  // What a slot carries: ordinary read, last-level entry read, dependent line read
  typedef enum logic [1:0] {K_PLAIN = 2'd0, K_LEAF = 2'd1, K_LINE = 2'd2} slot_kind_t;
endpackage

// File: rtl/xpf_first_one.sv
module xpf_first_one #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xpf_leaf_decode.sv
module xpf_leaf_decode #(
  parameter int FRAME_W   = 40,
  parameter int LIDX_W    = 6,
  parameter int LINE_BITS = 6
) (
  input  logic                                hit,
  input  logic                                present,
  input  logic [FRAME_W-1:0]                  frame,
  input  logic [LIDX_W-1:0]                   line,
  output logic                                release_line,
  output logic                                drop_line,
  output logic [FRAME_W+LIDX_W+LINE_BITS-1:0] target
);
  assign release_line = hit && present;
  assign drop_line    = hit && !present;
  assign target       = {frame, line, {LINE_BITS{1'b0}}};
endmodule

// File: rtl/xlat_prefetch_engine.sv
module xlat_prefetch_engine
  import xpf_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int PA_W      = 52,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int IDW       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_leaf,
  input  logic [PAGE_BITS-LINE_BITS-1:0]   req_line,
  input  logic [PA_W-1:0]                  req_addr,
  input  logic [TAG_W-1:0]                 req_tag,
  output logic                             mem_valid,
  input  logic                             mem_ready,
  output logic [PA_W-1:0]                  mem_addr,
  output logic [IDW-1:0]                   mem_id,
  input  logic                             memr_valid,
  input  logic [IDW-1:0]                   memr_id,
  input  logic [DATA_W-1:0]                memr_data,
  output logic                             rsp_valid,
  output logic [TAG_W-1:0]                 rsp_tag,
  output logic [DATA_W-1:0]                rsp_data,
  output logic                             fill_valid,
  output logic [PA_W-1:0]                  fill_addr,
  output logic [DATA_W-1:0]                fill_data
);
  localparam int IW      = IDW;
  localparam int LIDX_W  = PAGE_BITS - LINE_BITS;
  localparam int FRAME_W = PA_W - PAGE_BITS;

  slot_st_t   [SLOTS-1:0]         st;
  slot_kind_t [SLOTS-1:0]         kind;
  logic       [SLOTS-1:0][IW-1:0] link_q;
  logic [PA_W-1:0]   addr_q [SLOTS];
  logic [TAG_W-1:0]  tag_q  [SLOTS];
  logic [LIDX_W-1:0] line_q [SLOTS];

  logic [SLOTS-1:0] free_vec, free_rest, wait_vec;
  logic             have_a, have_b;
  logic [IW-1:0]    slot_a, slot_b, partner;
  logic             accept, rel_line, drop_line;
  logic [PA_W-1:0]  tgt;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      free_vec[i] = (st[i] == SL_FREE);
      wait_vec[i] = (st[i] == SL_WAIT);
    end
  end

  // first and second free slot for admission
  xpf_first_one #(.N(SLOTS), .IW(IW)) u_free_a (.vec(free_vec), .found(have_a), .idx(slot_a));
  assign free_rest = free_vec & ~(SLOTS'(1) << slot_a);
  xpf_first_one #(.N(SLOTS), .IW(IW)) u_free_b (.vec(free_rest), .found(have_b), .idx(slot_b));

  // lowest ready slot goes to DRAM
  xpf_first_one #(.N(SLOTS), .IW(IW)) u_issue (.vec(wait_vec), .found(mem_valid), .idx(mem_id));
  assign mem_addr = addr_q[mem_id];

  assign req_ready = req_leaf ? (have_a && have_b) : have_a;
  assign accept    = req_valid && req_ready;
  assign partner   = link_q[memr_id];

  xpf_leaf_decode #(.FRAME_W(FRAME_W), .LIDX_W(LIDX_W), .LINE_BITS(LINE_BITS)) u_decode (
    .hit          (memr_valid && (kind[memr_id] == K_LEAF)),
    .present      (memr_data[0]),
    .frame        (memr_data[PA_W-1:PAGE_BITS]),
    .line         (line_q[memr_id]),
    .release_line (rel_line),
    .drop_line    (drop_line),
    .target       (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        st[i]   <= SL_FREE;
        kind[i] <= K_PLAIN;
      end
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_data  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      fill_valid <= 1'b0;
      if (mem_valid && mem_ready) st[mem_id] <= SL_BUSY;
      if (memr_valid) begin
        st[memr_id] <= SL_FREE;
        if (kind[memr_id] == K_LINE) begin
          fill_valid <= 1'b1;
          fill_addr  <= addr_q[memr_id];
          fill_data  <= memr_data;
        end else begin
          rsp_valid <= 1'b1;
          rsp_tag   <= tag_q[memr_id];
          rsp_data  <= memr_data;
        end
      end
      if (rel_line) begin
        st[partner]     <= SL_WAIT;
        addr_q[partner] <= tgt;
      end
      if (drop_line) st[partner] <= SL_FREE;
      if (accept) begin
        st[slot_a]     <= SL_WAIT;
        kind[slot_a]   <= req_leaf ? K_LEAF : K_PLAIN;
        addr_q[slot_a] <= req_addr;
        tag_q[slot_a]  <= req_tag;
        line_q[slot_a] <= req_line;
        link_q[slot_a] <= slot_b;
        if (req_leaf) begin
          st[slot_b]   <= SL_HOLD;
          kind[slot_b] <= K_LINE;
        end
      end
    end
  end
endmodule

// File: rtl/xpf_checker.sv
module xpf_checker
  import xpf_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 3
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           req_valid,
  input logic                           req_ready,
  input logic                           req_leaf,
  input logic                           mem_valid,
  input logic [IW-1:0]                  mem_id,
  input logic                           memr_valid,
  input logic [IW-1:0]                  memr_id,
  input logic                           memr_present,
  input logic                           rsp_valid,
  input logic                           fill_valid,
  input slot_st_t   [SLOTS-1:0]         st,
  input slot_kind_t [SLOTS-1:0]         kind,
  input logic       [SLOTS-1:0][IW-1:0] link_q
);
  logic [SLOTS-1:0] free;
  always_comb begin
    for (int i = 0; i < SLOTS; i++) free[i] = (st[i] == SL_FREE);
  end

  AST_LEAF_ADMIT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_leaf |-> $countones(free) >= 2); // R2
  AST_PLAIN_ADMIT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> $countones(free) >= 1); // R2
  AST_ISSUE_READY_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> st[mem_id] == SL_WAIT); // R3
  AST_LINE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    memr_valid && kind[memr_id] == K_LEAF && memr_present |=> st[$past(link_q[memr_id])] == SL_WAIT); // R3
  AST_LINE_DROP: assert property (@(posedge clk) disable iff (rst)
    memr_valid && kind[memr_id] == K_LEAF && !memr_present |=> st[$past(link_q[memr_id])] == SL_FREE); // R5
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(memr_valid) && $past(kind[memr_id]) != K_LINE); // R6
  AST_FILL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(memr_valid) && $past(kind[memr_id]) == K_LINE); // R4
  AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fill_valid)); // R7
endmodule

bind xlat_prefetch_engine xpf_checker #(.SLOTS(SLOTS), .IW(IW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_leaf     (req_leaf),
  .mem_valid    (mem_valid),
  .mem_id       (mem_id),
  .memr_valid   (memr_valid),
  .memr_id      (memr_id),
  .memr_present (memr_data[0]),
  .rsp_valid    (rsp_valid),
  .fill_valid   (fill_valid),
  .st           (st),
  .kind         (kind),
  .link_q       (link_q)
);

// File: tb/xlat_prefetch_engine_test.sv
`timescale 1ns/1ps
module xlat_prefetch_engine_test;
  localparam int SLOTS = 8;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_leaf = 1'b1;
  logic [5:0]  req_line = '0;
  logic [51:0] req_addr = '0;
  logic [3:0]  req_tag = '0;
  logic        req_ready;
  logic        mem_valid, mem_ready = 1'b0;
  logic [51:0] mem_addr;
  logic [2:0]  mem_id;
  logic        memr_valid = 1'b0;
  logic [2:0]  memr_id = '0;
  logic [63:0] memr_data = '0;
  logic        rsp_valid, fill_valid;
  logic [3:0]  rsp_tag;
  logic [63:0] rsp_data, fill_data;
  logic [51:0] fill_addr;

  xlat_prefetch_engine uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_leaf(req_leaf),
    .req_line(req_line), .req_addr(req_addr), .req_tag(req_tag), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_id(mem_id), .memr_valid(memr_valid),
    .memr_id(memr_id), .memr_data(memr_data), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  always #4 clk = ~clk;

  // kind: 0 plain read, 1 entry read, 2 dependent line read
  typedef struct { logic [51:0] addr; int kind; logic [5:0] line; logic [3:0] tag; } rec_t;
  typedef struct { rec_t r; int due; logic [2:0] id; } dram_t;

  rec_t  stim[$];
  rec_t  wq[$];
  dram_t dq[$];
  int checks = 0, fails = 0, cyc = 0, occ = 0, occ_delta = 0;
  int fills_seen = 0, fills_want = 0, ready_low_seen = 0;
  bit stall = 0, jitter = 0, run = 0;
  logic [3:0] tag_ctr = '0;
  bit ex_rsp = 0, ex_fill = 0;
  string ex_rq = "R7";
  logic [3:0]  ex_tag;
  logic [63:0] ex_rdata, ex_fdata;
  logic [51:0] ex_faddr;

  function automatic logic [63:0] mem_word(logic [51:0] a);
    return {12'h000, a[39:0] ^ 40'hA5_0000_1234, 11'h000, ~a[3]};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push_req(logic [51:0] a, bit leaf, logic [5:0] ln);
    stim.push_back('{addr: a, kind: leaf ? 1 : 0, line: ln, tag: tag_ctr});
    tag_ctr++;
  endtask

  task automatic check_outputs();
    chk(rsp_valid == ex_rsp, ex_rq, "rsp_valid", 64'(rsp_valid), 64'(ex_rsp));
    if (ex_rsp && rsp_valid) begin
      chk(rsp_tag == ex_tag, ex_rq, "rsp_tag", 64'(rsp_tag), 64'(ex_tag));
      chk(rsp_data == ex_rdata, ex_rq, "rsp_data", rsp_data, ex_rdata);
    end
    chk(fill_valid == ex_fill, "R7", "fill_valid", 64'(fill_valid), 64'(ex_fill));
    if (ex_fill && fill_valid) begin
      chk(fill_addr == ex_faddr, "R4", "fill_addr", 64'(fill_addr), 64'(ex_faddr));
      chk(fill_data == ex_fdata, "R4", "fill_data", fill_data, ex_fdata);
    end
    if (fill_valid) fills_seen++;
    ex_rsp = 0; ex_fill = 0; ex_rq = "R7";
  endtask

  task automatic step();
    dram_t cur;
    bit have_resp;
    int found;
    logic [63:0] d;
    cyc++;
    occ += occ_delta;
    occ_delta = 0;
    check_outputs();
    if (stim.size() > 0) begin
      req_valid = 1'b1; req_addr = stim[0].addr; req_leaf = (stim[0].kind == 1);
      req_line = stim[0].line; req_tag = stim[0].tag;
    end else begin
      req_valid = 1'b0; req_leaf = 1'b1;
    end
    mem_ready = !stall && !(jitter && (cyc % 5 == 3 || cyc % 7 == 1));
    memr_valid = 1'b0;
    have_resp = 0;
    if (dq.size() > 0 && dq[0].due <= cyc) begin
      cur = dq.pop_front();
      have_resp = 1;
      memr_valid = 1'b1; memr_id = cur.id; memr_data = mem_word(cur.r.addr);
    end
    #1;
    // admission against the model's slot count (R2)
    if (req_valid) begin
      bit want = req_leaf ? (occ <= SLOTS - 2) : (occ < SLOTS);
      chk(req_ready == want, "R2", "req_ready", 64'(req_ready), 64'(want));
      if (req_valid && req_leaf && !req_ready) ready_low_seen++;
      if (req_ready) begin
        wq.push_back(stim[0]);
        occ_delta += req_leaf ? 2 : 1;
        void'(stim.pop_front());
      end
    end
    // every DRAM read must be one the model allows now (R1, R3)
    if (mem_valid && mem_ready) begin
      found = -1;
      foreach (wq[i]) if (found < 0 && wq[i].addr == mem_addr) found = i;
      chk(found >= 0, "R3", "issued address not allowed", 64'(mem_addr), 64'(0));
      if (found >= 0) begin
        dq.push_back('{r: wq[found], due: cyc + LAT, id: mem_id});
        wq.delete(found);
      end
    end
    if (have_resp) begin
      occ_delta -= 1;
      d = mem_word(cur.r.addr);
      if (cur.r.kind == 2) begin
        ex_fill = 1; ex_faddr = cur.r.addr; ex_fdata = d;
      end else begin
        ex_rsp = 1; ex_tag = cur.r.tag; ex_rdata = d;
        ex_rq = (cur.r.kind == 1) ? "R6" : "R1";
      end
      if (cur.r.kind == 1) begin
        if (d[0]) begin
          wq.push_back('{addr: {d[51:12], cur.r.line, 6'b000000}, kind: 2, line: 6'd0, tag: 4'd0});
          fills_want++;
        end else begin
          occ_delta -= 1;
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic drain();
    int guard = 0;
    while (stim.size() > 0 || wq.size() > 0 || dq.size() > 0) begin
      @(posedge clk);
      guard++;
      if (guard > 20000) begin
        fails++;
        $display("FAIL watchdog drain stalled actual=%0d expected=0", wq.size() + dq.size());
        finish_run();
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk); #2;
    chk(mem_valid == 1'b0, "R3", "idle mem_valid", 64'(mem_valid), 64'(0));
    chk(req_ready == 1'b1, "R5", "idle leaf req_ready (all slots free)", 64'(req_ready), 64'(1));
    chk(fills_seen == fills_want, "R5", "fill count", 64'(fills_seen), 64'(fills_want));
  endtask

  initial begin
    wait (run);
    forever begin
      @(negedge clk);
      step();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R8: idle after reset
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
    chk(fill_valid == 1'b0, "R8", "fill_valid after reset", 64'(fill_valid), 64'(0));
    chk(mem_valid == 1'b0, "R8", "mem_valid after reset", 64'(mem_valid), 64'(0));
    chk(req_ready == 1'b1, "R8", "leaf req_ready after reset", 64'(req_ready), 64'(1));
    run = 1;

    // R1: plain reads
    for (int k = 0; k < 4; k++) push_req(52'h1_0000 + 52'(k * 64), 1'b0, 6'd0);
    drain();

    // R3, R4, R6: present entries, line index at both ends
    push_req(52'h8_0000, 1'b1, 6'd0);
    push_req(52'h8_0010, 1'b1, 6'd63);
    push_req(52'h8_0020, 1'b1, 6'd21);
    drain();

    // R5: absent entries
    push_req(52'h8_0108, 1'b1, 6'd5);
    push_req(52'h8_0118, 1'b1, 6'd9);
    drain();

    // R2: one free slot left while an entry read waits
    stall = 1;
    for (int k = 0; k < 7; k++) push_req(52'h2_0000 + 52'(k * 64), 1'b0, 6'd0);
    push_req(52'h8_0200, 1'b1, 6'd33);
    push_req(52'h2_1000, 1'b0, 6'd0);
    repeat (30) @(posedge clk);
    stall = 0;
    drain();
    chk(ready_low_seen > 0, "R2", "entry read held off at one free slot", 64'(ready_low_seen), 64'(1));

    // mixed burst with DRAM back-pressure
    jitter = 1;
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 1) push_req(52'h3_0000 + 52'(k * 64), 1'b0, 6'd0);
      else push_req(52'h9_0000 + 52'(k * 16) + ((k % 4 == 2) ? 52'h8 : 52'h0), 1'b1, 6'((k * 5) % 64));
    end
    drain();

    finish_run();
  end
endmodule